// File: doc/BRIEF.md
# Configuration File Header Section Finder

This block reads a configuration file one byte at a time over a valid/ready input stream and looks for one named section in the file header. The first search after a reset or a restart checks that the file opens with a fixed 13-byte marker. The block then walks the header's tagged sections. Each section is a one-byte ASCII tag, a big-endian length, and that many content bytes. A section that is not wanted is read and thrown away. When the requested tag shows up, the block reports that section's length and stops before its content. From then on it forwards the input bytes to an output stream, so a downstream consumer can take the section body, such as the device configuration data.

Each search is launched by a one-cycle `start` with the wanted letter on `target_tag`. It ends with a one-cycle `done` pulse that carries a 2-bit outcome code. Several searches can run one after another on the same stream, and only the first one checks the marker. The `restart` input re-arms the marker check for a new file.

The controller has six states:
- **IDLE**: waits for a start.
- **PREAMBLE**: compares the marker bytes.
- **TAG**: reads a section tag.
- **LENGTH**: gathers the length bytes.
- **SKIP**: discards unwanted content.
- **PASS**: forwards bytes after a match.

The transitions are:
- IDLE or PASS → PREAMBLE on a start while the marker is unchecked.
- IDLE or PASS → TAG on a start once the marker is verified.
- IDLE or PASS → IDLE on a start after a bad marker, reporting code 3.
- PREAMBLE → TAG after the 13th correct byte.
- PREAMBLE → IDLE on a wrong byte.
- TAG → LENGTH on a legal tag.
- TAG → IDLE on an illegal tag.
- LENGTH → PASS on a match.
- LENGTH → SKIP on a non-match with content.
- LENGTH → TAG on a non-match with zero length.
- LENGTH → IDLE on a length error.
- SKIP → TAG when the content is exhausted.
- TAG, LENGTH or SKIP → IDLE when the byte budget runs out.
- Any state → IDLE on restart.

Top module: `bitfile_hdr_parser`

## Requirements
- R1: The first search after reset or restart must see the exact bytes 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01. The first wrong byte ends the search with done_code 3 and raises file_bad. While file_bad is high, in_ready stays low and every start returns done_code 3, until restart.
- R2: A section is a tag byte, a big-endian length, and then the content. On a match, sect_len holds the decoded length while done is high.
- R3: Tags 'a'..'d' (0x61..0x64) carry a 2-byte length. Tag 'e' (0x65) carries a 4-byte length, assembled most significant byte first into 32 bits.
- R4: A tag byte outside 0x61..0x65 ends the search with done_code 1 (not found).
- R5: A non-'e' section whose length exceeds 255 ends the search with done_code 2 (parse error), even if its tag is the requested one.
- R6: A match ends the search with done_code 0 and consumes no content. Afterwards out_valid follows in_valid, out_data equals in_data, and in_ready follows out_ready, until the next start or restart.
- R7: A section whose tag differs from the requested one has its content bytes consumed and discarded, and the walk goes on to the next tag. A zero length means the next byte is a tag.
- R8: Tag, length and content bytes of a search count toward a budget of SEARCH_LIMIT (100) bytes. If the byte that reaches the budget does not itself end the search, the search ends with done_code 1 and no further byte is taken.
- R9: Once the marker is accepted, later starts begin at a tag byte without checking it again. Restart clears both that state and file_bad.
- R10: done is a one-cycle pulse, raised in the cycle after the byte (or start) that ends the search. After reset, done, in_ready, out_valid and file_bad are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| restart | input | 1 | Re-arms the marker check and clears file_bad |
| start | input | 1 | Launches a search (taken in IDLE or PASS) |
| target_tag | input | 8 | Wanted section letter, captured with start |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Input byte taken this cycle |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Forwarded byte present (PASS only) |
| out_ready | input | 1 | Downstream can take a byte |
| out_data | output | 8 | Forwarded byte |
| done | output | 1 | One-cycle end-of-search pulse |
| done_code | output | 2 | 0 found, 1 not found, 2 parse error, 3 bad file |
| sect_len | output | 32 | Length of the matched section |
| file_bad | output | 1 | Marker mismatch seen since last restart |

## Verification
Some properties are checked by assertions on every cycle:
- The byte budget never passes its limit.
- A short-length section never reports a found length above 255.
- file_bad is sticky and blocks intake.
- Forwarding happens only after a verified marker.
- The verified-marker state survives until restart.

Other behaviours only the bench scenarios can show:
- The exact cycle and code of each outcome.
- Skipping of unwanted and zero-length sections.
- Most-significant-first assembly of the 4-byte length.
- Where the budget boundary falls.
- Forwarded byte values and the back-pressure path.

// File: rtl/hdrp_pkg.sv
package hdrp_pkg;
    localparam int BYTE_W    = 8;
    localparam int LEN_W     = 32;
    localparam int MARK_LEN  = 13;
    localparam int MARK_IW   = $clog2(MARK_LEN);
    localparam logic [BYTE_W-1:0] TAG_FIRST = 8'h61;
    localparam logic [BYTE_W-1:0] TAG_LAST  = 8'h65;
    localparam logic [BYTE_W-1:0] TAG_WIDE  = 8'h65;
    localparam int SHORT_MAX = 255;
    localparam logic [2:0] NARROW_BYTES = 3'd2;
    localparam logic [2:0] WIDE_BYTES   = 3'd4;

    typedef enum logic [1:0] {
        ST_FOUND   = 2'd0,
        ST_MISS    = 2'd1,
        ST_PARSE   = 2'd2,
        ST_BADFILE = 2'd3
    } outcome_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PREAMBLE,
        S_TAG,
        S_LENGTH,
        S_SKIP,
        S_PASS
    } walk_state_e;
endpackage

// File: rtl/hdrp_marker_rom.sv
module hdrp_marker_rom
    import hdrp_pkg::*;
(
    input  logic [MARK_IW-1:0] idx,
    output logic [BYTE_W-1:0]  expect_byte,
    output logic               is_last
);
    always_comb begin
        unique case (idx)
            4'd1:                         expect_byte = 8'h09;
            4'd2, 4'd4, 4'd6, 4'd8:       expect_byte = 8'h0F;
            4'd3, 4'd5, 4'd7, 4'd9:       expect_byte = 8'hF0;
            4'd12:                        expect_byte = 8'h01;
            default:                      expect_byte = 8'h00;
        endcase
    end

    assign is_last = (idx == MARK_IW'(MARK_LEN - 1));
endmodule

// File: rtl/hdrp_budget.sv
module hdrp_budget #(
    parameter int LIMIT = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [$clog2(LIMIT+1)-1:0] count,
    output logic          hit_last
);
    localparam int CW = $clog2(LIMIT + 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + CW'(1);
        end
    end

    assign hit_last = inc && (count == CW'(LIMIT - 1));
endmodule

// File: rtl/bitfile_hdr_parser.sv
module bitfile_hdr_parser
    import hdrp_pkg::*;
#(
    parameter int SEARCH_LIMIT = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart,
    input  logic        start,
    input  logic [7:0]  target_tag,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  out_data,
    output logic        done,
    output logic [1:0]  done_code,
    output logic [31:0] sect_len,
    output logic        file_bad
);
    localparam int CW = $clog2(SEARCH_LIMIT + 1);

    walk_state_e          state_q, state_d;
    logic                 mark_ok_q, mark_ok_d;
    logic                 bad_q, bad_d;
    logic [BYTE_W-1:0]    want_q, want_d;
    logic [BYTE_W-1:0]    tag_q, tag_d;
    logic [2:0]           hdr_left_q, hdr_left_d;
    logic [LEN_W-1:0]     acc_q, acc_d;
    logic [LEN_W-1:0]     skip_q, skip_d;
    logic [MARK_IW-1:0]   midx_q, midx_d;
    logic                 done_q, done_d;
    outcome_e             code_q, code_d;
    logic [LEN_W-1:0]     slen_q, slen_d;

    logic                 accept;
    logic                 searching;
    logic                 budget_clr;
    logic                 budget_last;
    logic [CW-1:0]        budget_cnt;
    logic [BYTE_W-1:0]    mark_byte;
    logic                 mark_last;
    logic                 ended;
    logic [LEN_W-1:0]     acc_next;

    hdrp_marker_rom u_mark (
        .idx         (midx_q),
        .expect_byte (mark_byte),
        .is_last     (mark_last)
    );

    hdrp_budget #(.LIMIT(SEARCH_LIMIT)) u_budget (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (budget_clr),
        .inc      (accept && searching),
        .count    (budget_cnt),
        .hit_last (budget_last)
    );

    assign accept     = in_valid && in_ready;
    assign searching  = (state_q == S_TAG) || (state_q == S_LENGTH) || (state_q == S_SKIP);
    assign budget_clr = restart || (start && ((state_q == S_IDLE) || (state_q == S_PASS)));
    assign acc_next   = {acc_q[LEN_W-9:0], in_data};

    // State and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            mark_ok_q  <= 1'b0;
            bad_q      <= 1'b0;
            want_q     <= '0;
            tag_q      <= '0;
            hdr_left_q <= '0;
            acc_q      <= '0;
            skip_q     <= '0;
            midx_q     <= '0;
            done_q     <= 1'b0;
            code_q     <= ST_FOUND;
            slen_q     <= '0;
        end else begin
            state_q    <= state_d;
            mark_ok_q  <= mark_ok_d;
            bad_q      <= bad_d;
            want_q     <= want_d;
            tag_q      <= tag_d;
            hdr_left_q <= hdr_left_d;
            acc_q      <= acc_d;
            skip_q     <= skip_d;
            midx_q     <= midx_d;
            done_q     <= done_d;
            code_q     <= code_d;
            slen_q     <= slen_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d    = state_q;
        mark_ok_d  = mark_ok_q;
        bad_d      = bad_q;
        want_d     = want_q;
        tag_d      = tag_q;
        hdr_left_d = hdr_left_q;
        acc_d      = acc_q;
        skip_d     = skip_q;
        midx_d     = midx_q;
        done_d     = 1'b0;
        code_d     = code_q;
        slen_d     = slen_q;
        ended      = 1'b0;

        if (restart) begin
            state_d   = S_IDLE;
            mark_ok_d = 1'b0;
            bad_d     = 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE, S_PASS: begin
                    if (start) begin
                        want_d = target_tag;
                        if (bad_q) begin
                            done_d  = 1'b1;
                            code_d  = ST_BADFILE;
                            state_d = S_IDLE;
                        end else if (!mark_ok_q) begin
                            midx_d  = '0;
                            state_d = S_PREAMBLE;
                        end else begin
                            state_d = S_TAG;
                        end
                    end
                end
                S_PREAMBLE: begin
                    if (accept) begin
                        if (in_data != mark_byte) begin
                            bad_d   = 1'b1;
                            done_d  = 1'b1;
                            code_d  = ST_BADFILE;
                            state_d = S_IDLE;
                        end else if (mark_last) begin
                            mark_ok_d = 1'b1;
                            state_d   = S_TAG;
                        end else begin
                            midx_d = midx_q + MARK_IW'(1);
                        end
                    end
                end
                S_TAG: begin
                    if (accept) begin
                        if ((in_data < TAG_FIRST) || (in_data > TAG_LAST)) begin
                            ended   = 1'b1;
                            done_d  = 1'b1;
                            code_d  = ST_MISS;
                            state_d = S_IDLE;
                        end else begin
                            tag_d      = in_data;
                            hdr_left_d = (in_data == TAG_WIDE) ? WIDE_BYTES : NARROW_BYTES;
                            acc_d      = '0;
                            state_d    = S_LENGTH;
                        end
                    end
                end
                S_LENGTH: begin
                    if (accept) begin
                        acc_d      = acc_next;
                        hdr_left_d = hdr_left_q - 3'd1;
                        if (hdr_left_q == 3'd1) begin
                            if ((tag_q != TAG_WIDE) && (acc_next > LEN_W'(SHORT_MAX))) begin
                                ended   = 1'b1;
                                done_d  = 1'b1;
                                code_d  = ST_PARSE;
                                state_d = S_IDLE;
                            end else if (tag_q == want_q) begin
                                ended   = 1'b1;
                                done_d  = 1'b1;
                                code_d  = ST_FOUND;
                                slen_d  = acc_next;
                                state_d = S_PASS;
                            end else if (acc_next == '0) begin
                                state_d = S_TAG;
                            end else begin
                                skip_d  = acc_next;
                                state_d = S_SKIP;
                            end
                        end
                    end
                end
                S_SKIP: begin
                    if (accept) begin
                        skip_d = skip_q - LEN_W'(1);
                        if (skip_q == LEN_W'(1)) begin
                            state_d = S_TAG;
                        end
                    end
                end
                default: state_d = S_IDLE;
            endcase

            if (budget_last && !ended) begin
                done_d  = 1'b1;
                code_d  = ST_MISS;
                state_d = S_IDLE;
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            S_PREAMBLE, S_TAG, S_LENGTH, S_SKIP: in_ready = 1'b1;
            S_PASS:                              in_ready = out_ready;
            default:                             in_ready = 1'b0;
        endcase
        out_valid = (state_q == S_PASS) && in_valid;
        out_data  = in_data;
        done      = done_q;
        done_code = code_q;
        sect_len  = slen_q;
        file_bad  = bad_q;
    end

    AST_BUDGET_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        budget_cnt <= CW'(SEARCH_LIMIT)); // R8
    AST_SHORT_FOUND_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_code == ST_FOUND && tag_q != TAG_WIDE) |-> (sect_len <= 32'd255)); // R5
    AST_BADFILE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (file_bad && !restart) |=> file_bad); // R1
    AST_BADFILE_NO_INTAKE: assert property (@(posedge clk) disable iff (!rst_n)
        file_bad |-> !in_ready); // R1
    AST_PASS_NEEDS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> mark_ok_q); // R6
    AST_MARK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_ok_q && !restart) |=> mark_ok_q); // R9
endmodule

// File: tb/bitfile_hdr_parser_tb.sv
module bitfile_hdr_parser_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  target_tag = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_data;
    logic        done;
    logic [1:0]  done_code;
    logic [31:0] sect_len;
    logic        file_bad;

    int n_cmp = 0;
    int n_bad = 0;

    logic [1:0]  q_code[$];
    logic [31:0] q_len[$];
    string       q_req[$];
    logic [7:0]  q_out[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bitfile_hdr_parser u_dut (
        .clk(clk), .rst_n(rst_n), .restart(restart), .start(start),
        .target_tag(target_tag), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .done(done), .done_code(done_code),
        .sect_len(sect_len), .file_bad(file_bad)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Monitor: outcome scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q_code.size() == 0) begin
                check("R10 unexpected done", 32'(done_code), 32'hFFFF);
            end else begin
                string r;
                logic [1:0] c;
                logic [31:0] l;
                r = q_req.pop_front();
                c = q_code.pop_front();
                l = q_len.pop_front();
                check(r, 32'(done_code), 32'(c));
                if (c == 2'd0) check(r, sect_len, l);
            end
        end
    end

    // Monitor: forwarded byte scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (q_out.size() == 0) check("R6 unexpected out byte", 32'(out_data), 32'hFFFF);
            else check("R6 forwarded byte", 32'(out_data), 32'(q_out.pop_front()));
        end
    end

    task automatic expect_done(input logic [1:0] c, input logic [31:0] l, input string r);
        q_code.push_back(c);
        q_len.push_back(l);
        q_req.push_back(r);
    endtask

    task automatic send(input logic [7:0] b);
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic go(input logic [7:0] t);
        @(posedge clk); #1;
        start = 1'b1; target_tag = t;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic rearm();
        @(posedge clk); #1;
        restart = 1'b1;
        @(posedge clk); #1;
        restart = 1'b0;
    endtask

    task automatic send_mark();
        logic [7:0] m [13] = '{8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h0F,
                               8'hF0, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01};
        for (int i = 0; i < 13; i++) send(m[i]);
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        check("R10 reset done", 32'(done), 0);
        check("R10 reset in_ready", 32'(in_ready), 0);
        check("R10 reset out_valid", 32'(out_valid), 0);
        check("R10 reset file_bad", 32'(file_bad), 0);
        rst_n = 1'b1;

        // R2 R3 R7: skip 'a', find 'b'
        go(8'h62);
        expect_done(2'd0, 32'd3, "R2 found b");
        send_mark();
        send(8'h61); send(8'h00); send(8'h05);
        for (int i = 0; i < 5; i++) send(8'h30 + 8'(i));
        send(8'h62); send(8'h00); send(8'h03);
        settle();
        // R6 forwarding
        q_out.push_back(8'hA1); q_out.push_back(8'hA2); q_out.push_back(8'hA3);
        send(8'hA1); send(8'hA2); send(8'hA3);
        @(posedge clk); #1;
        out_ready = 1'b0; in_valid = 1'b1; in_data = 8'h55;
        @(negedge clk);
        check("R6 back-pressure in_ready", 32'(in_ready), 0);
        check("R6 out_valid follows in_valid", 32'(out_valid), 1);
        @(posedge clk); #1;
        in_valid = 1'b0; out_ready = 1'b1;
        check("R6 sect_len held", sect_len, 32'd3);

        // R9 R3: second search, no marker, wide length MSB first
        go(8'h65);
        expect_done(2'd0, 32'h12345678, "R3 wide length");
        send(8'h65); send(8'h12); send(8'h34); send(8'h56); send(8'h78);
        settle();
        check("R9 marker not rechecked", 32'(file_bad), 0);

        // R4 R7: zero-length skip then illegal tag
        rearm();
        go(8'h64);
        expect_done(2'd1, 32'd0, "R4 illegal tag");
        send_mark();
        send(8'h63); send(8'h00); send(8'h00);
        send(8'h61); send(8'h00); send(8'h02); send(8'hEE); send(8'hEF);
        send(8'h7A);
        settle();
        @(negedge clk);
        check("R4 no intake after miss", 32'(in_ready), 0);

        // R5: requested short tag with length 256
        rearm();
        go(8'h63);
        expect_done(2'd2, 32'd0, "R5 parse error");
        send_mark();
        send(8'h63); send(8'h01); send(8'h00);
        settle();

        // R8: budget exhausted inside content
        rearm();
        go(8'h65);
        expect_done(2'd1, 32'd0, "R8 budget miss");
        send_mark();
        send(8'h61); send(8'h00); send(8'hFF);
        for (int i = 0; i < 97; i++) send(8'(i));
        settle();
        @(posedge clk); #1;
        in_valid = 1'b1;
        @(negedge clk);
        check("R8 no byte after budget", 32'(in_ready), 0);
        @(posedge clk); #1;
        in_valid = 1'b0;

        // R8: match completing on the 100th byte
        rearm();
        go(8'h62);
        expect_done(2'd0, 32'd7, "R8 found at limit");
        send_mark();
        send(8'h61); send(8'h00); send(8'd94);
        for (int i = 0; i < 94; i++) send(8'h20);
        send(8'h62); send(8'h00); send(8'h07);
        settle();

        // R1: marker mismatch at fourth byte
        rearm();
        go(8'h61);
        expect_done(2'd3, 32'd0, "R1 bad marker");
        send(8'h00); send(8'h09); send(8'h0F); send(8'h00);
        settle();
        check("R1 file_bad set", 32'(file_bad), 1);
        @(posedge clk); #1;
        in_valid = 1'b1;
        @(negedge clk);
        check("R1 intake blocked", 32'(in_ready), 0);
        @(posedge clk); #1;
        in_valid = 1'b0;
        expect_done(2'd3, 32'd0, "R1 start after bad");
        go(8'h61);
        settle();

        // R9: restart clears file_bad and re-arms marker
        rearm();
        @(negedge clk);
        check("R9 restart clears file_bad", 32'(file_bad), 0);
        go(8'h61);
        expect_done(2'd0, 32'd1, "R9 marker checked again");
        send_mark();
        send(8'h61); send(8'h00); send(8'h01);
        settle();

        check("R10 all outcomes seen", 32'(q_code.size()), 0);
        check("R6 all bytes forwarded", 32'(q_out.size()), 0);
        summary();
    end
endmodule